// File: doc/BRIEF.md
# Operand Specifier Resolver

This block turns one operand specifier of a 16-bit, eight-register machine into something an execution stage can use: a register designator or an effective memory address. A specifier is a 3-bit addressing mode plus a 3-bit register number. The block owns the register file, so it also carries out the register side effects of a mode: the post-increment, the pre-decrement, and the program-counter advance after an index word. It reads index words and pointers through a single memory read port with a request/ready handshake. Register 6 serves as the stack pointer and register 7 as the program counter. Both may be named in any mode, including as the index base.

The surrounding pipeline loads and inspects registers through a write port and a combinational read port. It presents a specifier with a one-cycle `start` while `busy` is low, then waits for the one-cycle `done` pulse. At that pulse, `res_is_reg` and `res_val` give either the register number or the operand address.

The controller has four states:
- `ST_IDLE` waits for `start`.
- `ST_INDEX` reads the index word at the program counter.
- `ST_PTR` reads a pointer.
- `ST_DONE` presents the result for one cycle.

The transitions are:
- IDLE to DONE, taken by the register, register-indirect, post-increment and pre-decrement modes.
- IDLE to PTR, taken by the two deferred step modes.
- IDLE to INDEX, taken by the two indexed modes.
- INDEX to DONE, when the index word arrives in plain indexed mode.
- INDEX to PTR, when the index word arrives in deferred indexed mode.
- PTR to DONE, when the pointer arrives.
- DONE to IDLE, always.

Top module: `opspec_resolver`

## Requirements
- R1: Mode 0 (register): `done` rises on the cycle after acceptance with `res_is_reg`=1 and `res_val` equal to the register number. No memory access is made and no register changes.
- R2: Mode 1 (register indirect): `done` follows acceptance by one cycle with `res_is_reg`=0 and `res_val`=Rn. No memory access is made and Rn is unchanged.
- R3: Mode 2 (post-increment): `res_val` is the old Rn and Rn grows by the step. No memory access is made and `done` follows acceptance by one cycle.
- R4: Mode 4 (pre-decrement): Rn shrinks by the step and `res_val` is the new Rn. No memory access is made and `done` follows acceptance by one cycle.
- R5: The step for modes 2 and 4 is 1 when `byte_op`=1 and n is 0..5. It is 2 for word operands and whenever n is 6 or 7. Modes 3 and 5 always step by 2. All arithmetic wraps modulo 2^16.
- R6: Mode 3 (post-increment deferred): one read is made at the old Rn, Rn grows by 2, and `res_val` is the word read.
- R7: Mode 5 (pre-decrement deferred): Rn shrinks by 2, one read is made at the new Rn, and `res_val` is the word read.
- R8: Mode 6 (indexed): one read is made at R7 and R7 grows by 2. `res_val` is the word read plus Rn; when n=7, the advanced R7 is used.
- R9: Mode 7 (indexed deferred): proceeds as in R8, then a second read is made at the sum. `res_val` is that second word.
- R10: `mem_req` and `mem_addr` hold steady until `mem_ready` is seen. `done` is a single-cycle pulse with `mem_req` low, given only after the last access. `busy` is high from acceptance through `done`, and a `start` while busy is ignored.
- R11: With `wr_en`=1 while idle, `wr_data` is written to register `wr_sel` at the clock edge. `rd_data` always shows register `rd_sel`. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Present a specifier (accepted when not busy) |
| spec_mode | input | 3 | Addressing mode 0..7 |
| spec_reg | input | 3 | Register number |
| byte_op | input | 1 | Operand is a byte |
| busy | output | 1 | A specifier is in progress |
| done | output | 1 | One-cycle result strobe |
| res_is_reg | output | 1 | Result names a register |
| res_val | output | 16 | Register number or operand address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ready | input | 1 | Read data valid, access complete |
| mem_rdata | input | 16 | Read data |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register to write |
| wr_data | input | 16 | Register write data |
| rd_sel | input | 3 | Register to read |
| rd_data | output | 16 | Selected register contents |

## Verification
Modes without memory traffic must show `done` exactly one clock after the accepting edge. The bench therefore samples `done` at the very next falling edge, with zero wait allowed. Memory modes finish one clock after the edge that sees the last `mem_ready`. The memory model inserts zero to two random wait cycles, so the bench polls `done` on falling edges under a bound. It then compares the result and the logged read addresses against values computed from a shadow register array. Register side effects are checked through the read port in the idle cycles that follow each `done`, before the next specifier starts.

// File: rtl/opspec_pkg.sv
package opspec_pkg;
    typedef enum logic [2:0] {
        AM_REG    = 3'd0,
        AM_DEF    = 3'd1,
        AM_INC    = 3'd2,
        AM_INCDEF = 3'd3,
        AM_DEC    = 3'd4,
        AM_DECDEF = 3'd5,
        AM_IDX    = 3'd6,
        AM_IDXDEF = 3'd7
    } am_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INDEX = 2'd1,
        ST_PTR   = 2'd2,
        ST_DONE  = 2'd3
    } st_t;

    localparam int SP_NUM = 6;
    localparam int PC_NUM = 7;
endpackage

// File: rtl/opspec_regfile.sv
module opspec_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_we,
    input  logic [RW-1:0] ext_sel,
    input  logic [W-1:0]  ext_data,
    input  logic          upd_we,
    input  logic [RW-1:0] upd_sel,
    input  logic [W-1:0]  upd_data,
    output logic [W-1:0]  regs [NREG]
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (upd_we && upd_sel == RW'(g)) begin
                regs[g] <= upd_data;
            end else if (ext_we && ext_sel == RW'(g)) begin
                regs[g] <= ext_data;
            end
        end
    end
endmodule

// File: rtl/opspec_step.sv
module opspec_step
    import opspec_pkg::*;
#(
    parameter int W  = 16,
    parameter int RW = 3
) (
    input  am_t           mode,
    input  logic [RW-1:0] sel,
    input  logic          byte_op,
    output logic [W-1:0]  step
);
    localparam logic [RW-1:0] SP_SEL = RW'(SP_NUM);

    logic deferred;
    logic narrow;

    always_comb begin
        deferred = (mode == AM_INCDEF) || (mode == AM_DECDEF);
        narrow   = byte_op && !deferred && (sel < SP_SEL);
        step     = narrow ? W'(1) : W'(2);
    end
endmodule

// File: rtl/opspec_resolver.sv
module opspec_resolver
    import opspec_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   spec_mode,
    input  logic [2:0]   spec_reg,
    input  logic         byte_op,
    output logic         busy,
    output logic         done,
    output logic         res_is_reg,
    output logic [15:0]  res_val,
    output logic         mem_req,
    output logic [15:0]  mem_addr,
    input  logic         mem_ready,
    input  logic [15:0]  mem_rdata,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [15:0]  wr_data,
    input  logic [2:0]   rd_sel,
    output logic [15:0]  rd_data
);
    localparam int RW = $clog2(NREG);
    localparam logic [RW-1:0] PC_SEL = RW'(PC_NUM);
    localparam logic [W-1:0]  TWO    = W'(2);

    st_t           state_q, state_d;
    logic [W-1:0]  addr_q,  addr_d;
    logic [W-1:0]  res_q,   res_d;
    logic          isreg_q, isreg_d;
    logic          defer_q, defer_d;
    logic [RW-1:0] sel_q,   sel_d;

    logic          upd_we;
    logic [RW-1:0] upd_sel;
    logic [W-1:0]  upd_data;
    logic [W-1:0]  regs [NREG];
    logic [W-1:0]  step;
    logic [W-1:0]  rv, pc, base, sum;
    am_t           mode_in;

    assign mode_in = am_t'(spec_mode);

    opspec_regfile #(.W(W), .NREG(NREG), .RW(RW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_we   (wr_en && (state_q == ST_IDLE)),
        .ext_sel  (wr_sel),
        .ext_data (wr_data),
        .upd_we   (upd_we),
        .upd_sel  (upd_sel),
        .upd_data (upd_data),
        .regs     (regs)
    );

    opspec_step #(.W(W), .RW(RW)) u_step (
        .mode    (mode_in),
        .sel     (spec_reg),
        .byte_op (byte_op),
        .step    (step)
    );

    assign rd_data = regs[rd_sel];
    assign rv      = regs[spec_reg];
    assign pc      = regs[PC_SEL];
    assign base    = (sel_q == PC_SEL) ? (pc + TWO) : regs[sel_q];
    assign sum     = mem_rdata + base;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            res_q   <= '0;
            isreg_q <= 1'b0;
            defer_q <= 1'b0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            res_q   <= res_d;
            isreg_q <= isreg_d;
            defer_q <= defer_d;
            sel_q   <= sel_d;
        end
    end

    // next state, captured values and register side effects
    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        res_d    = res_q;
        isreg_d  = isreg_q;
        defer_d  = defer_q;
        sel_d    = sel_q;
        upd_we   = 1'b0;
        upd_sel  = spec_reg;
        upd_data = rv;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    sel_d   = spec_reg;
                    isreg_d = (mode_in == AM_REG);
                    defer_d = 1'b0;
                    unique case (mode_in)
                        AM_REG: begin
                            res_d   = W'(spec_reg);
                            state_d = ST_DONE;
                        end
                        AM_DEF: begin
                            res_d   = rv;
                            state_d = ST_DONE;
                        end
                        AM_INC: begin
                            res_d    = rv;
                            upd_we   = 1'b1;
                            upd_data = rv + step;
                            state_d  = ST_DONE;
                        end
                        AM_INCDEF: begin
                            addr_d   = rv;
                            upd_we   = 1'b1;
                            upd_data = rv + step;
                            state_d  = ST_PTR;
                        end
                        AM_DEC: begin
                            res_d    = rv - step;
                            upd_we   = 1'b1;
                            upd_data = rv - step;
                            state_d  = ST_DONE;
                        end
                        AM_DECDEF: begin
                            addr_d   = rv - step;
                            upd_we   = 1'b1;
                            upd_data = rv - step;
                            state_d  = ST_PTR;
                        end
                        AM_IDX, AM_IDXDEF: begin
                            addr_d  = pc;
                            defer_d = (mode_in == AM_IDXDEF);
                            state_d = ST_INDEX;
                        end
                    endcase
                end
            end
            ST_INDEX: begin
                if (mem_ready) begin
                    upd_we   = 1'b1;
                    upd_sel  = PC_SEL;
                    upd_data = pc + TWO;
                    if (defer_q) begin
                        addr_d  = sum;
                        state_d = ST_PTR;
                    end else begin
                        res_d   = sum;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_PTR: begin
                if (mem_ready) begin
                    res_d   = mem_rdata;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        mem_req    = (state_q == ST_INDEX) || (state_q == ST_PTR);
        mem_addr   = addr_q;
        res_val    = res_q;
        res_is_reg = isreg_q;
    end
endmodule

// File: rtl/opspec_checker.sv
module opspec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [2:0]  spec_mode,
    input logic [2:0]  spec_reg,
    input logic        busy,
    input logic        done,
    input logic        res_is_reg,
    input logic [15:0] res_val,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_ready
);
    logic accept;
    assign accept = start && !busy;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req && busy); // R10

    AST_REG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && spec_mode == 3'd0 |=> done && res_is_reg
            && res_val == {13'd0, $past(spec_reg)} && !mem_req); // R1

    AST_FAST_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (spec_mode == 3'd1 || spec_mode == 3'd2 || spec_mode == 3'd4)
            |=> done && !res_is_reg && !mem_req); // R2

    AST_MEM_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (spec_mode == 3'd3 || spec_mode == 3'd5 || spec_mode[2:1] == 2'b11)
            |=> !done && mem_req); // R6

    AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_is_reg |-> res_val < 16'd8); // R1
endmodule

bind opspec_resolver opspec_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .spec_mode  (spec_mode),
    .spec_reg   (spec_reg),
    .busy       (busy),
    .done       (done),
    .res_is_reg (res_is_reg),
    .res_val    (res_val),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready)
);

// File: tb/tb_opspec_resolver.sv
`timescale 1ns/1ps
module tb_opspec_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  spec_mode = 3'd0;
    logic [2:0]  spec_reg = 3'd0;
    logic        byte_op = 1'b0;
    logic        busy, done, res_is_reg, mem_req;
    logic [15:0] res_val, mem_addr, rd_data;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = 16'd0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [2:0]  rd_sel = 3'd0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [15:0] sh [8];
    int acc_n = 0;
    logic [15:0] acc_addr [4];
    int wait_cnt = 0;

    always #2.5 clk = ~clk;

    opspec_resolver dut (
        .clk(clk), .rst_n(rst_n), .start(start), .spec_mode(spec_mode),
        .spec_reg(spec_reg), .byte_op(byte_op), .busy(busy), .done(done),
        .res_is_reg(res_is_reg), .res_val(res_val), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder with random wait states
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                wait_cnt = int'($urandom % 3);
            end else if (mem_req) begin
                if (wait_cnt == 0) begin
                    mem_ready = 1'b1;
                    mem_rdata = memf(mem_addr);
                    if (acc_n < 4) acc_addr[acc_n] = mem_addr;
                    acc_n++;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic wreg(input int i, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(i); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        sh[i] = v;
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.5;
            chk(tag, rd_data, sh[i]);
        end
    endtask

    task automatic run_spec(input int m, input int n, input bit bo, input bit inject, input string tag);
        logic [15:0] exp_res, a0, a1, r, st, idx;
        int exp_acc;
        bit exp_reg;
        int t;
        string ttag;
        r = sh[n];
        st = (bo && n < 6) ? 16'd1 : 16'd2;
        exp_acc = 0; exp_reg = 1'b0; a0 = 16'd0; a1 = 16'd0;
        case (m)
            0: begin exp_res = 16'(n); exp_reg = 1'b1; end
            1: exp_res = r;
            2: begin exp_res = r; sh[n] = r + st; end
            3: begin a0 = r; exp_res = memf(r); sh[n] = r + 16'd2; exp_acc = 1; end
            4: begin sh[n] = r - st; exp_res = sh[n]; end
            5: begin sh[n] = r - 16'd2; a0 = sh[n]; exp_res = memf(a0); exp_acc = 1; end
            default: begin
                a0 = sh[7]; idx = memf(a0); sh[7] = sh[7] + 16'd2;
                exp_res = idx + sh[n]; exp_acc = 1;
                if (m == 7) begin a1 = exp_res; exp_res = memf(a1); exp_acc = 2; end
            end
        endcase
        ttag = inject ? "R10" : tag;
        @(negedge clk);
        acc_n = 0;
        start = 1'b1; spec_mode = 3'(m); spec_reg = 3'(n); byte_op = bo;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        if (inject && !done) begin
            start = 1'b1; spec_mode = 3'($urandom % 8); spec_reg = 3'($urandom % 8);
            byte_op = 1'($urandom % 2);
            @(negedge clk);
            start = 1'b0;
            t = 1;
        end
        while (!done && t < 60) begin
            @(negedge clk);
            t++;
        end
        if (m == 0 || m == 1 || m == 2 || m == 4) chk("R10", 16'(t), 16'd0);
        chk(tag, {15'd0, done}, 16'd1);
        chk(tag, {15'd0, res_is_reg}, {15'd0, exp_reg});
        chk(ttag, res_val, exp_res);
        chk(tag, 16'(acc_n), 16'(exp_acc));
        if (exp_acc >= 1) chk(tag, acc_addr[0], a0);
        if (exp_acc >= 2) chk(tag, acc_addr[1], a1);
        @(negedge clk);
        chk("R10", {15'd0, done}, 16'd0);
        check_regs(ttag);
    endtask

    function automatic string mtag(input int m);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R6";
            4: return "R4";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) sh[i] = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R11", {15'd0, busy}, 16'd0);
        chk("R11", {15'd0, done}, 16'd0);
        chk("R11", {15'd0, mem_req}, 16'd0);
        check_regs("R11");
        // write / read port
        for (int i = 0; i < 8; i++) wreg(i, 16'h1000 + 16'(i * 16'h0111));
        check_regs("R11");
        // directed corner cases
        run_spec(0, 5, 1'b0, 1'b0, "R1");
        run_spec(1, 3, 1'b0, 1'b0, "R2");
        run_spec(2, 2, 1'b1, 1'b0, "R5");   // byte step 1
        run_spec(2, 6, 1'b1, 1'b0, "R5");   // SP steps 2 even for bytes
        run_spec(4, 7, 1'b1, 1'b0, "R5");   // PC steps 2 even for bytes
        run_spec(4, 1, 1'b1, 1'b0, "R5");
        run_spec(3, 4, 1'b1, 1'b0, "R5");   // deferred step always 2
        run_spec(5, 0, 1'b1, 1'b0, "R5");
        wreg(3, 16'd0);
        run_spec(4, 3, 1'b0, 1'b0, "R4");   // wrap below zero
        wreg(2, 16'hFFFF);
        run_spec(2, 2, 1'b1, 1'b0, "R3");   // wrap above max
        run_spec(6, 7, 1'b0, 1'b0, "R8");   // PC-relative base
        run_spec(6, 6, 1'b0, 1'b0, "R8");
        run_spec(7, 7, 1'b0, 1'b0, "R9");
        run_spec(7, 2, 1'b0, 1'b0, "R9");
        run_spec(3, 5, 1'b0, 1'b1, "R6");   // start while busy ignored
        run_spec(7, 1, 1'b0, 1'b1, "R9");
        // random mix
        for (int k = 0; k < 80; k++) begin
            int m;
            int n;
            if (($urandom % 4) == 0) wreg(int'($urandom % 8), 16'($urandom));
            m = int'($urandom % 8);
            n = int'($urandom % 8);
            run_spec(m, n, 1'($urandom % 2), 1'($urandom % 3 == 0), mtag(m));
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule